// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 8-bit tri-state buses, called port A and port B. It can pass data in either direction. Each direction has its own storage bank and three active-low controls: a direction enable, a capture enable and a drive enable. Because each direction has its own bank and controls, a word can be parked in one direction while the other direction captures or drives on its own.

The direction enable qualifies both capture and drive. For a direction to capture, its direction enable and its capture enable must both be low. For it to drive the far-side bus, its direction enable and its drive enable must both be low. When a direction is not driving, it leaves the far-side bus at high impedance.

The storage is written for an FPGA fabric. Each bank is a clock-enabled register rather than a true level latch. The bank follows its input bus on every clock edge while capture is qualified, and it holds once the capture enable goes high. The drive qualifier is registered too. A synchronous active-high reset clears both banks and releases both buses.

Top module: `latched_xcvr`

## Requirements
- R1: A clock edge with `rst` high clears both storage banks to zero and releases both buses. After reset ends and drive is qualified, each bus shows 0x00.
- R2: At a clock edge with `ce_ab_n` and `le_ab_n` both low, the A-to-B bank loads the value on `port_a`. While it keeps following, a driven `port_b` shows the value that `port_a` carried one edge earlier.
- R3: At a clock edge with `le_ab_n` high, the A-to-B bank keeps its contents. Lowering `le_ab_n` again (with `ce_ab_n` low) resumes following `port_a`.
- R4: At a clock edge with `ce_ab_n` high, the A-to-B bank does not change, whatever `le_ab_n` is, and `port_b` is released.
- R5: At a clock edge with `ce_ab_n` and `oe_ab_n` both low, `port_b` is driven with the A-to-B bank from the next cycle on. At an edge where either is high, `port_b` goes to high impedance.
- R6: At a clock edge with `ce_ba_n` and `le_ba_n` both low, the B-to-A bank loads `port_b`.
- R7: At a clock edge with `le_ba_n` high, the B-to-A bank keeps its contents.
- R8: At a clock edge with `ce_ba_n` high, the B-to-A bank does not change, and `port_a` is released.
- R9: At a clock edge with `ce_ba_n` and `oe_ba_n` both low, `port_a` is driven with the B-to-A bank from the next cycle on. At an edge where either is high, `port_a` goes to high impedance.
- R10: The two directions operate at the same time. Each port can be driven by its own direction in the same cycle, each from its own bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_ab_n | input | 1 | A-to-B direction enable, active low |
| le_ab_n | input | 1 | A-to-B capture enable, active low |
| oe_ab_n | input | 1 | A-to-B drive enable for port B, active low |
| ce_ba_n | input | 1 | B-to-A direction enable, active low |
| le_ba_n | input | 1 | B-to-A capture enable, active low |
| oe_ba_n | input | 1 | B-to-A drive enable for port A, active low |
| port_a | inout | WIDTH | Bus A: source for A-to-B, driven by B-to-A |
| port_b | inout | WIDTH | Bus B: source for B-to-A, driven by A-to-B |

## Verification
Both the bank write and the drive qualifier are registered. A change on a control or a source bus therefore shows on the far-side bus after exactly one rising edge. Reset and release also take effect after that one edge.

The bench applies each stimulus on a falling edge. It then waits through the next rising edge and samples on the following falling edge, where each result is due.

Pull-ups on both buses make a released bus read 0xFF. No data value used in the stimulus is 0xFF, so a released bus cannot be mistaken for a driven one.

The bench drives a bus only while the block's own drive toward that bus is off, both before and after the edge. It reports any overlap as contention.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Per-direction control group, all active low.
  typedef struct packed {
    logic ce_n;  // direction qualifier
    logic le_n;  // capture enable
    logic oe_n;  // drive enable
  } dir_ctl_t;

  typedef enum int unsigned {
    DIR_AB = 0,
    DIR_BA = 1
  } dir_e;

  localparam int unsigned NUM_DIRS = 2;

endpackage

// File: rtl/xcvr_lane.sv
// One direction: a clock-enabled storage bank plus a registered drive qualifier.
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dir_ctl_t         ctl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] store_q,
  output logic             drive_q
);

  logic capture_en;
  logic drive_en;

  assign capture_en = !ctl.ce_n && !ctl.le_n;
  assign drive_en   = !ctl.ce_n && !ctl.oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= drive_en;
      if (capture_en) begin
        store_q <= din;
      end
    end
  end

endmodule

// File: rtl/xcvr_tri.sv
// Tri-state pad driver: drives the bus only while enabled.
module xcvr_tri #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             en,
  input  logic [WIDTH-1:0] val,
  inout  wire  [WIDTH-1:0] pad
);

  assign pad = en ? val : {WIDTH{1'bz}};

endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_ab_n,
  input  logic             le_ab_n,
  input  logic             oe_ab_n,
  input  logic             ce_ba_n,
  input  logic             le_ba_n,
  input  logic             oe_ba_n,
  inout  wire  [WIDTH-1:0] port_a,
  inout  wire  [WIDTH-1:0] port_b
);

  dir_ctl_t         lane_ctl   [NUM_DIRS];
  logic [WIDTH-1:0] lane_din   [NUM_DIRS];
  logic [WIDTH-1:0] lane_store [NUM_DIRS];
  logic             lane_drive [NUM_DIRS];

  assign lane_ctl[DIR_AB] = {ce_ab_n, le_ab_n, oe_ab_n};
  assign lane_ctl[DIR_BA] = {ce_ba_n, le_ba_n, oe_ba_n};
  assign lane_din[DIR_AB] = port_a;
  assign lane_din[DIR_BA] = port_b;

  for (genvar g = 0; g < NUM_DIRS; g++) begin : g_lane
    xcvr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .ctl     (lane_ctl[g]),
      .din     (lane_din[g]),
      .store_q (lane_store[g]),
      .drive_q (lane_drive[g])
    );
  end

  logic [WIDTH-1:0] ab_store;
  logic [WIDTH-1:0] ba_store;
  logic             ab_drive;
  logic             ba_drive;

  assign ab_store = lane_store[DIR_AB];
  assign ba_store = lane_store[DIR_BA];
  assign ab_drive = lane_drive[DIR_AB];
  assign ba_drive = lane_drive[DIR_BA];

  xcvr_tri #(.WIDTH(WIDTH)) u_drv_b (
    .en  (ab_drive),
    .val (ab_store),
    .pad (port_b)
  );

  xcvr_tri #(.WIDTH(WIDTH)) u_drv_a (
    .en  (ba_drive),
    .val (ba_store),
    .pad (port_a)
  );

endmodule

// File: rtl/latched_xcvr_chk.sv
module latched_xcvr_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_ab_n,
  input logic             le_ab_n,
  input logic             oe_ab_n,
  input logic             ce_ba_n,
  input logic             le_ba_n,
  input logic             oe_ba_n,
  input logic [WIDTH-1:0] port_a,
  input logic [WIDTH-1:0] port_b,
  input logic [WIDTH-1:0] ab_store,
  input logic [WIDTH-1:0] ba_store,
  input logic             ab_drive,
  input logic             ba_drive
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ab_store == '0 && ba_store == '0 && !ab_drive && !ba_drive));

  assert_ab_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_ab_n && !le_ab_n) |=> ab_store == $past(port_a));

  assert_ab_hold_R3: assert property (@(posedge clk) disable iff (rst)
    le_ab_n |=> $stable(ab_store));

  assert_ab_gate_R4: assert property (@(posedge clk) disable iff (rst)
    ce_ab_n |=> ($stable(ab_store) && !ab_drive));

  assert_ab_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (!ce_ab_n && !oe_ab_n) |=> ab_drive);

  assert_b_value_R5: assert property (@(posedge clk) disable iff (rst)
    ab_drive |-> port_b == ab_store);

  assert_ba_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (!ce_ba_n && !le_ba_n) |=> ba_store == $past(port_b));

  assert_ba_hold_R7: assert property (@(posedge clk) disable iff (rst)
    le_ba_n |=> $stable(ba_store));

  assert_ba_gate_R8: assert property (@(posedge clk) disable iff (rst)
    ce_ba_n |=> ($stable(ba_store) && !ba_drive));

  assert_ba_drive_R9: assert property (@(posedge clk) disable iff (rst)
    (!ce_ba_n && !oe_ba_n) |=> ba_drive);

  assert_a_value_R9: assert property (@(posedge clk) disable iff (rst)
    ba_drive |-> port_a == ba_store);

  assert_both_drive_R10: assert property (@(posedge clk) disable iff (rst)
    (!ce_ab_n && !oe_ab_n && !ce_ba_n && !oe_ba_n) |=> (ab_drive && ba_drive));

endmodule

bind latched_xcvr latched_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_ab_n  (ce_ab_n),
  .le_ab_n  (le_ab_n),
  .oe_ab_n  (oe_ab_n),
  .ce_ba_n  (ce_ba_n),
  .le_ba_n  (le_ba_n),
  .oe_ba_n  (oe_ba_n),
  .port_a   (port_a),
  .port_b   (port_b),
  .ab_store (ab_store),
  .ba_store (ba_store),
  .ab_drive (ab_drive),
  .ba_drive (ba_drive)
);

// File: tb/latched_xcvr_tb.sv
module latched_xcvr_tb;

  localparam int unsigned W  = 8;
  localparam int unsigned NV = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_ab_n = 1'b1, le_ab_n = 1'b1, oe_ab_n = 1'b1;
  logic ce_ba_n = 1'b1, le_ba_n = 1'b1, oe_ba_n = 1'b1;
  logic         tb_a_en = 1'b0, tb_b_en = 1'b0;
  logic [W-1:0] tb_a_val = '0, tb_b_val = '0;
  wire  [W-1:0] a_bus;
  wire  [W-1:0] b_bus;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 4 ns period

  assign a_bus = tb_a_en ? tb_a_val : {W{1'bz}};
  assign b_bus = tb_b_en ? tb_b_val : {W{1'bz}};

  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup (a_bus[i]);
    pullup (b_bus[i]);
  end

  latched_xcvr #(.WIDTH(W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .ce_ab_n (ce_ab_n),
    .le_ab_n (le_ab_n),
    .oe_ab_n (oe_ab_n),
    .ce_ba_n (ce_ba_n),
    .le_ba_n (le_ba_n),
    .oe_ba_n (oe_ba_n),
    .port_a  (a_bus),
    .port_b  (b_bus)
  );

  // Vector: ctl[5:0] = {ce_ab,le_ab,oe_ab,ce_ba,le_ba,oe_ba}, a_en, a_val,
  // b_en, b_val, expected A, expected B, requirement number.
  localparam logic [43:0] VEC [NV] = '{
    {6'b111111, 1'b0, 8'h00, 1'b0, 8'h00, 8'hFF, 8'hFF, 4'd5},   // R5 idle, released
    {6'b001111, 1'b1, 8'h3C, 1'b0, 8'h00, 8'h3C, 8'hFF, 4'd2},   // R2 follow, no drive
    {6'b000111, 1'b1, 8'h5A, 1'b0, 8'h00, 8'h5A, 8'h5A, 4'd2},   // R2 follow + drive
    {6'b010111, 1'b1, 8'hA5, 1'b0, 8'h00, 8'hA5, 8'h5A, 4'd3},   // R3 hold
    {6'b010111, 1'b1, 8'h0F, 1'b0, 8'h00, 8'h0F, 8'h5A, 4'd3},   // R3 hold
    {6'b100111, 1'b1, 8'hF0, 1'b0, 8'h00, 8'hF0, 8'hFF, 4'd4},   // R4 gated off
    {6'b010111, 1'b1, 8'hF0, 1'b0, 8'h00, 8'hF0, 8'h5A, 4'd4},   // R4 no capture seen
    {6'b000111, 1'b1, 8'h11, 1'b0, 8'h00, 8'h11, 8'h11, 4'd3},   // R3 release to follow
    {6'b011111, 1'b1, 8'h22, 1'b0, 8'h00, 8'h22, 8'hFF, 4'd5},   // R5 drive off
    {6'b111001, 1'b0, 8'h00, 1'b1, 8'h77, 8'hFF, 8'h77, 4'd6},   // R6 follow, no drive
    {6'b111000, 1'b0, 8'h00, 1'b1, 8'h66, 8'h66, 8'h66, 4'd6},   // R6 follow + drive
    {6'b111010, 1'b0, 8'h00, 1'b1, 8'h99, 8'h66, 8'h99, 4'd7},   // R7 hold
    {6'b111100, 1'b0, 8'h00, 1'b1, 8'h44, 8'hFF, 8'h44, 4'd8},   // R8 gated off
    {6'b111010, 1'b0, 8'h00, 1'b1, 8'h44, 8'h66, 8'h44, 4'd8},   // R8 no capture seen
    {6'b010010, 1'b0, 8'h00, 1'b0, 8'h00, 8'h66, 8'h11, 4'd10},  // R10 both drive
    {6'b111010, 1'b0, 8'h00, 1'b0, 8'h00, 8'h66, 8'hFF, 4'd9},   // R9 A still driven
    {6'b111011, 1'b0, 8'h00, 1'b0, 8'h00, 8'hFF, 8'hFF, 4'd9}    // R9 drive off
  };

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input int req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [5:0] c);
    {ce_ab_n, le_ab_n, oe_ab_n, ce_ba_n, le_ba_n, oe_ba_n} = c;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [5:0] prev_ctl;
    prev_ctl = 6'b111111;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: released buses right after reset
    check(a_bus, 8'hFF, 1, "reset port_a");
    check(b_bus, 8'hFF, 1, "reset port_b");

    for (int v = 0; v < NV; v++) begin
      logic [5:0] c;
      c = VEC[v][43:38];
      // Contention guard: the bench must not drive a bus the block may drive.
      if (VEC[v][37] && (!c[2] && !c[0] || !prev_ctl[2] && !prev_ctl[0])) begin
        errors++;
        $display("FAIL R9 contention on port_a vector %0d actual 1 expected 0", v);
      end
      if (VEC[v][28] && (!c[5] && !c[3] || !prev_ctl[5] && !prev_ctl[3])) begin
        errors++;
        $display("FAIL R5 contention on port_b vector %0d actual 1 expected 0", v);
      end
      set_ctl(c);
      tb_a_en  = VEC[v][37];
      tb_a_val = VEC[v][36:29];
      tb_b_en  = VEC[v][28];
      tb_b_val = VEC[v][27:20];
      step();
      check(a_bus, VEC[v][19:12], int'(VEC[v][3:0]), $sformatf("vec %0d port_a", v));
      check(b_bus, VEC[v][11:4],  int'(VEC[v][3:0]), $sformatf("vec %0d port_b", v));
      prev_ctl = c;
    end

    // R1: reset while both directions drive releases both buses.
    tb_a_en = 1'b0;
    tb_b_en = 1'b0;
    set_ctl(6'b010010);
    rst = 1'b1;
    step();
    check(a_bus, 8'hFF, 1, "reset mid-run port_a");
    check(b_bus, 8'hFF, 1, "reset mid-run port_b");
    rst = 1'b0;
    step();
    // R1: banks were cleared, so drive shows zero.
    check(a_bus, 8'h00, 1, "post-reset port_a");
    check(b_bus, 8'h00, 1, "post-reset port_b");

    // R2: streaming follow, one-edge delay from port_a to port_b.
    set_ctl(6'b111111);
    step();
    set_ctl(6'b000111);
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] d;
      d = W'((k * 37 + 5) % 255);
      tb_a_en  = 1'b1;
      tb_a_val = d;
      step();
      check(b_bus, d, 2, $sformatf("stream %0d port_b", k));
    end
    tb_a_en = 1'b0;
    set_ctl(6'b111111);
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule